// File: doc/BRIEF.md
# Handshake Ordering Monitor

This block is a passive observer for one memory-mapped bus port with five VALID/READY channels: read address, read data, write address, write data and write response. It never drives any of them. It follows how transfers relate across channels and catches a counterpart that answers too early. Examples are read data with no address outstanding, or a write response before both the address and the final data beat have been accepted. It also catches a master that keeps write data back until its write address has been accepted.

Three 4-bit counters track the work in flight. The first counts read addresses accepted and not yet closed by a final read beat. The second counts write bursts whose last beat was accepted and that still await a response. The third counts write addresses still awaiting a response. Each kind of violation sets its own sticky bit in a registered flag vector, and a registered summary output goes high when any bit is set. A one-cycle clear input wipes the flags. Tie the monitor to the port wires inside a simulation or hardware debug build, and read or trigger on the flags.

Top module: `hsmon_top`

## Requirements
- R1: A synchronous active-high `rst` drives `err_flags` and `err_any` low in the next cycle and zeroes all three in-flight counters.
- R2: Flag bit 0 sets when `r_valid` goes from low to high while the read-in-flight count is zero. An address accepted in the same cycle does not count.
- R3: Flag bit 2 sets when any read beat completes its handshake while the read-in-flight count is zero. The count drops by one on each accepted beat with `r_last` high.
- R4: Flag bit 1 sets when `b_valid` goes from low to high while the completed-write-burst count or the write-address count is zero.
- R5: Flag bit 3 sets when a write response completes its handshake while either write count is zero. Any nonzero write count drops by one on that handshake.
- R6: Flag bit 4 sets when `w_valid` rises either in the cycle the write address is accepted or in the cycle after, following at least one cycle in which `aw_valid` was high, `aw_ready` low and `w_valid` low.
- R7: Each counter saturates at 15. An increment at 15 with no matching decrement sets a flag: bit 5 for reads, bit 6 for completed write bursts, bit 7 for write addresses.
- R8: Flags are sticky. A cycle with `clr` high drives every flag low in the next cycle, whatever is detected in that cycle. Without `clr`, a set flag stays set.
- R9: Flags and `err_any` are registered and change one cycle after the edge at which the violation is sampled. `err_any` always equals the OR of `err_flags`.
- R10: Legal traffic sets no flag. This includes write data accepted before its address, in the same cycle as its address, and multi-beat write data offered while the address stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all checks sample on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the sticky flags |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_last | input | 1 | Final read beat |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_last | input | 1 | Final write beat |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| err_flags | output | 8 | Sticky violation bits, index as listed in the requirements |
| err_any | output | 1 | OR of all violation bits |

## Verification
The hardest conditions to reach from the ports are the saturation flags. Each needs fifteen unanswered handshakes of one kind before the sixteenth can trip it. The bench gets there with directed bursts of back-to-back address or last-beat handshakes and keeps the opposite channel idle, so no decrement interferes. The withheld-data pattern is also delicate, because it depends on the cycles both before and after the address handshake. A stimulus table walks stall-then-accept sequences with data rising in each of the two cycles. It also includes a stall with data already offered, which must stay clean.

// File: rtl/hsmon_pkg.sv
package hsmon_pkg;
  localparam int ERR_N       = 8;
  localparam int E_RD_EARLY  = 0;
  localparam int E_B_EARLY   = 1;
  localparam int E_RD_EXCESS = 2;
  localparam int E_B_EXCESS  = 3;
  localparam int E_W_HELD    = 4;
  localparam int E_RD_OVF    = 5;
  localparam int E_WD_OVF    = 6;
  localparam int E_AW_OVF    = 7;
endpackage

// File: rtl/hsmon_ocnt.sv
// Saturating up/down in-flight counter with an overflow pulse.
module hsmon_ocnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero,
  output logic         ovf
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  assign zero = (cnt == '0);
  assign ovf  = inc && !dec && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (dec && zero) begin
      // decrement with nothing in flight: keep only the increment
      if (inc) cnt <= ONE;
    end else if (!ovf && (inc != dec)) begin
      cnt <= inc ? cnt + ONE : cnt - ONE;
    end
  end
endmodule

// File: rtl/hsmon_wwait.sv
// Detects write data held back until the write address is accepted.
module hsmon_wwait (
  input  logic clk,
  input  logic rst,
  input  logic aw_valid,
  input  logic aw_ready,
  input  logic w_valid,
  output logic viol
);
  logic aw_hs, w_q, stall_q, armed_q, w_rise;

  assign aw_hs  = aw_valid && aw_ready;
  assign w_rise = w_valid && !w_q;
  assign viol   = w_rise && ((aw_hs && stall_q) || armed_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q     <= 1'b0;
      stall_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      w_q     <= w_valid;
      armed_q <= aw_hs && stall_q && !w_valid;
      if (w_valid || aw_hs)
        stall_q <= 1'b0;
      else if (aw_valid && !aw_ready)
        stall_q <= 1'b1;
    end
  end
endmodule

// File: rtl/hsmon_flags.sv
// Sticky flag register with a registered summary bit.
module hsmon_flags #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] flags,
  output logic         any
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr)   flags[i] <= 1'b0;
      else if (set[i])  flags[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) any <= 1'b0;
    else            any <= |(flags | set);
  end
endmodule

// File: rtl/hsmon_top.sv
module hsmon_top
  import hsmon_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ar_valid,
  input  logic             ar_ready,
  input  logic             r_valid,
  input  logic             r_ready,
  input  logic             r_last,
  input  logic             aw_valid,
  input  logic             aw_ready,
  input  logic             w_valid,
  input  logic             w_ready,
  input  logic             w_last,
  input  logic             b_valid,
  input  logic             b_ready,
  output logic [ERR_N-1:0] err_flags,
  output logic             err_any
);
  logic ar_hs, r_hs, r_end, aw_hs, w_end, b_hs;
  logic r_q, b_q, r_rise, b_rise;
  logic [CNT_W-1:0] rd_cnt, wd_cnt, aw_cnt;
  logic rd_zero, wd_zero, aw_zero;
  logic rd_ovf, wd_ovf, aw_ovf, held;
  logic [ERR_N-1:0] err_set;

  assign ar_hs  = ar_valid && ar_ready;
  assign r_hs   = r_valid && r_ready;
  assign r_end  = r_hs && r_last;
  assign aw_hs  = aw_valid && aw_ready;
  assign w_end  = w_valid && w_ready && w_last;
  assign b_hs   = b_valid && b_ready;
  assign r_rise = r_valid && !r_q;
  assign b_rise = b_valid && !b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      r_q <= r_valid;
      b_q <= b_valid;
    end
  end

  hsmon_ocnt #(.W(CNT_W)) u_rd_cnt (
    .clk(clk), .rst(rst), .inc(ar_hs), .dec(r_end),
    .cnt(rd_cnt), .zero(rd_zero), .ovf(rd_ovf));

  hsmon_ocnt #(.W(CNT_W)) u_wd_cnt (
    .clk(clk), .rst(rst), .inc(w_end), .dec(b_hs),
    .cnt(wd_cnt), .zero(wd_zero), .ovf(wd_ovf));

  hsmon_ocnt #(.W(CNT_W)) u_aw_cnt (
    .clk(clk), .rst(rst), .inc(aw_hs), .dec(b_hs),
    .cnt(aw_cnt), .zero(aw_zero), .ovf(aw_ovf));

  hsmon_wwait u_wwait (
    .clk(clk), .rst(rst), .aw_valid(aw_valid), .aw_ready(aw_ready),
    .w_valid(w_valid), .viol(held));

  always_comb begin
    err_set              = '0;
    err_set[E_RD_EARLY]  = r_rise && rd_zero;
    err_set[E_RD_EXCESS] = r_hs && rd_zero;
    err_set[E_B_EARLY]   = b_rise && (wd_zero || aw_zero);
    err_set[E_B_EXCESS]  = b_hs && (wd_zero || aw_zero);
    err_set[E_W_HELD]    = held;
    err_set[E_RD_OVF]    = rd_ovf;
    err_set[E_WD_OVF]    = wd_ovf;
    err_set[E_AW_OVF]    = aw_ovf;
  end

  hsmon_flags #(.N(ERR_N)) u_flags (
    .clk(clk), .rst(rst), .clr(clr), .set(err_set),
    .flags(err_flags), .any(err_any));
endmodule

// File: rtl/hsmon_chk.sv
module hsmon_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             ar_valid,
  input logic             ar_ready,
  input logic             r_valid,
  input logic             r_ready,
  input logic             r_last,
  input logic             b_valid,
  input logic             b_ready,
  input logic [7:0]       err_flags,
  input logic             err_any,
  input logic [CNT_W-1:0] rd_cnt,
  input logic [CNT_W-1:0] wd_cnt,
  input logic [CNT_W-1:0] aw_cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (err_flags == '0 && !err_any));

  assert_rd_early_R2: assert property (@(posedge clk) disable iff (rst)
    (r_valid && !$past(r_valid) && rd_cnt == '0 && !clr) |=> err_flags[0]);

  assert_rd_excess_R3: assert property (@(posedge clk) disable iff (rst)
    (r_valid && r_ready && rd_cnt == '0 && !clr) |=> err_flags[2]);

  assert_b_early_R4: assert property (@(posedge clk) disable iff (rst)
    (b_valid && !$past(b_valid) && (wd_cnt == '0 || aw_cnt == '0) && !clr)
    |=> err_flags[1]);

  assert_b_excess_R5: assert property (@(posedge clk) disable iff (rst)
    (b_valid && b_ready && (wd_cnt == '0 || aw_cnt == '0) && !clr)
    |=> err_flags[3]);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (ar_valid && ar_ready && !(r_valid && r_ready && r_last) &&
     rd_cnt == TOP && !clr) |=> err_flags[5]);

  assert_saturate_R7: assert property (@(posedge clk) disable iff (rst)
    (ar_valid && ar_ready && !(r_valid && r_ready && r_last) && rd_cnt == TOP)
    |=> rd_cnt == TOP);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> err_flags == '0);

  assert_any_R9: assert property (@(posedge clk) disable iff (rst)
    err_any == (|err_flags));
endmodule

bind hsmon_top hsmon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr),
  .ar_valid(ar_valid), .ar_ready(ar_ready),
  .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last),
  .b_valid(b_valid), .b_ready(b_ready),
  .err_flags(err_flags), .err_any(err_any),
  .rd_cnt(rd_cnt), .wd_cnt(wd_cnt), .aw_cnt(aw_cnt));

// File: tb/hsmon_top_tb.sv
`timescale 1ns/1ps
module hsmon_top_tb;
  logic clk = 1'b0, rst = 1'b1, clr = 1'b0;
  logic ar_valid = 0, ar_ready = 0, r_valid = 0, r_ready = 0, r_last = 0;
  logic aw_valid = 0, aw_ready = 0, w_valid = 0, w_ready = 0, w_last = 0;
  logic b_valid = 0, b_ready = 0;
  logic [7:0] err_flags;
  logic err_any;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hsmon_top u_dut (
    .clk(clk), .rst(rst), .clr(clr),
    .ar_valid(ar_valid), .ar_ready(ar_ready),
    .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last),
    .aw_valid(aw_valid), .aw_ready(aw_ready),
    .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready),
    .err_flags(err_flags), .err_any(err_any));

  // {clr, ar v/r, r v/r/last, aw v/r, w v/r/last, b v/r, expected flags}
  localparam logic [20:0] TBL [34] = '{
    {13'b0_00_000_00_000_00, 8'h00}, // 0  idle (R10)
    {13'b0_11_000_00_000_00, 8'h00}, // 1  read address accepted (R10)
    {13'b0_00_111_00_000_00, 8'h00}, // 2  final read beat (R10)
    {13'b0_00_000_00_000_00, 8'h00}, // 3
    {13'b0_00_000_00_111_00, 8'h00}, // 4  data before address (R10)
    {13'b0_00_000_11_000_00, 8'h00}, // 5
    {13'b0_00_000_00_000_11, 8'h00}, // 6  legal response (R10)
    {13'b0_00_000_00_000_00, 8'h00}, // 7
    {13'b0_00_000_11_111_00, 8'h00}, // 8  address and data together (R10)
    {13'b0_00_000_00_000_11, 8'h00}, // 9
    {13'b0_00_100_00_000_00, 8'h01}, // 10 read valid with nothing out (R2)
    {13'b0_00_111_00_000_00, 8'h05}, // 11 read beat accepted, none out (R3)
    {13'b1_00_000_00_000_00, 8'h00}, // 12 clear (R8)
    {13'b0_11_111_00_000_00, 8'h05}, // 13 data same cycle as address (R2, R3)
    {13'b1_00_000_00_000_00, 8'h00}, // 14
    {13'b0_00_000_00_000_10, 8'h02}, // 15 response valid, no write (R4)
    {13'b0_00_000_00_000_11, 8'h0A}, // 16 response accepted (R5)
    {13'b1_00_000_00_000_00, 8'h00}, // 17
    {13'b0_00_000_00_111_00, 8'h00}, // 18 data only
    {13'b0_00_000_00_000_11, 8'h0A}, // 19 response with no address (R4, R5)
    {13'b1_00_000_00_000_00, 8'h00}, // 20
    {13'b0_00_000_10_000_00, 8'h00}, // 21 address stalls, no data
    {13'b0_00_000_11_000_00, 8'h00}, // 22 address accepted, still no data
    {13'b0_00_000_00_111_00, 8'h10}, // 23 data rises just after (R6)
    {13'b0_00_000_00_000_11, 8'h10}, // 24
    {13'b1_00_000_00_000_00, 8'h00}, // 25
    {13'b0_00_000_10_110_00, 8'h00}, // 26 stall with data offered (R10)
    {13'b0_00_000_11_111_00, 8'h00}, // 27
    {13'b0_00_000_00_000_11, 8'h00}, // 28
    {13'b0_00_111_00_000_00, 8'h00}, // 29 read left open by vector 13
    {13'b0_00_000_10_000_00, 8'h00}, // 30 stall, no data
    {13'b0_00_000_11_111_00, 8'h10}, // 31 data rises at acceptance (R6)
    {13'b0_00_000_00_000_11, 8'h10}, // 32
    {13'b1_00_000_00_000_00, 8'h00}  // 33
  };

  task automatic drive(input logic [12:0] v);
    {clr, ar_valid, ar_ready, r_valid, r_ready, r_last,
     aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready} = v;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    drive(13'b0);
    check("R1 flags after reset", err_flags, 8'h00);
    check("R1 any after reset", {7'b0, err_any}, 8'h00);
    rst = 1'b0;
    drive(13'b0);

    for (int i = 0; i < 34; i++) begin
      drive(TBL[i][20:8]);
      check($sformatf("table vector %0d flags", i), err_flags, TBL[i][7:0]);
      check($sformatf("R9 table vector %0d any", i),
            {7'b0, err_any}, {7'b0, |TBL[i][7:0]});
    end

    // R7: read count saturation
    for (int k = 0; k < 15; k++) drive(13'b0_11_000_00_000_00);
    check("R7 read count at 15", err_flags, 8'h00);
    drive(13'b0_11_000_00_000_00);
    check("R7 read overflow", err_flags, 8'h20);
    check("R9 any on overflow", {7'b0, err_any}, 8'h01);
    drive(13'b1_00_000_00_000_00);
    check("R8 clear", err_flags, 8'h00);

    for (int k = 0; k < 16; k++) drive(13'b0_00_000_11_000_00);
    check("R7 write address overflow", err_flags, 8'h80);
    drive(13'b1_00_000_00_000_00);
    for (int k = 0; k < 16; k++) drive(13'b0_00_000_00_111_00);
    check("R7 write burst overflow", err_flags, 8'h40);

    // R8: sticky through idle cycles
    for (int k = 0; k < 5; k++) drive(13'b0);
    check("R8 sticky", err_flags, 8'h40);

    // R1: reset clears flags and counters (15 reads were in flight)
    rst = 1'b1;
    drive(13'b0);
    check("R1 reset clears flags", err_flags, 8'h00);
    rst = 1'b0;
    drive(13'b0);
    drive(13'b0_00_111_00_000_00);
    check("R1 read count zero after reset", err_flags, 8'h05);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule